// File: doc/BRIEF.md
# Dual-Channel LED Blink Generator

Two programmable blink waveforms are generated and routed to four active-low LED pins. Each channel has an 8-bit prescale value and an 8-bit duty value. An 8-bit phase counter per channel advances once every `prescale+1` pulses of a shared base-tick enable. That enable stands for a timebase of 256 × 152 Hz, so a full blink period lasts `(prescale+1)/152` seconds. A channel is "on" while its phase is below the duty value, which gives a duty cycle of `duty/256`.

A 2-bit mode field per LED chooses one of four sources: released (high-impedance), forced on, channel 0, or channel 1. Each pin is modelled as an open-drain driver with a data line and an output enable. Prescale and duty values come from an external register file. They are copied into working copies only when the phase counter wraps, and once in the first cycle after reset, so a new setting never cuts a period short.

Top module: `led_blink_dimmer`

## Requirements
- R1: In the first clock cycle after reset is released, both channels capture the current prescale and duty inputs. Both phases start at 0, so an LED in mode 10 is on at once when duty0 > 0.
- R2: Mode 00 releases the LED: `led_oe[i]`=0 and `led_n[i]`=1. In every mode `led_n[i]` is the inverse of `led_oe[i]`.
- R3: Mode 01 drives the LED on: `led_oe[i]`=1 and `led_n[i]`=0.
- R4: Mode 10 makes the LED follow channel 0. The LED is on exactly while phase0 < duty0.
- R5: Mode 11 makes the LED follow channel 1. The LED is on exactly while phase1 < duty1.
- R6: The mode of LED i is bits [2i+1:2i] of `led_sel`, so LED0 uses bits 1:0 and LED3 uses bits 7:6.
- R7: With a working duty of 0, the channel is never on.
- R8: A channel's phase advances by one after every `prescale+1` cycles that have `tick` high. Cycles with `tick` low do not advance it.
- R9: A change to the prescale or duty input takes effect only at the next phase wrap.
- R10: The phase wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base timebase enable, one pulse per 1/38912 s |
| presc0 | input | 8 | Channel 0 prescale value |
| duty0 | input | 8 | Channel 0 duty value |
| presc1 | input | 8 | Channel 1 prescale value |
| duty1 | input | 8 | Channel 1 duty value |
| led_sel | input | 8 | Four 2-bit LED mode fields |
| led_n | output | 4 | Active-low LED data |
| led_oe | output | 4 | LED output enable (0 = released) |

## Verification
The hardest case to reach from the ports is a register update that arrives in mid-period. The output must keep using the old duty until the phase wraps, so the observable difference lies hundreds of ticks away from the write. The stimulus first counts ticks to a known phase past the old duty threshold. It then changes duty and checks that the LED stays off. It then steps to exactly the wrap and well beyond it, to see the new value take hold. The prescale divider and the 255-to-0 wrap are reached by running full periods with a non-zero prescale after a fresh reset.

// File: rtl/led_blink_dimmer.sv
module led_blink_dimmer #(
  parameter int CW   = 8,
  parameter int NLED = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CW-1:0]     presc0,
  input  logic [CW-1:0]     duty0,
  input  logic [CW-1:0]     presc1,
  input  logic [CW-1:0]     duty1,
  input  logic [2*NLED-1:0] led_sel,
  output logic [NLED-1:0]   led_n,
  output logic [NLED-1:0]   led_oe
);
  logic fresh;
  logic [1:0][CW-1:0] psc_in, duty_in, psc_q, duty_q, pre_q, phase;
  logic [1:0] step, wrap, blink_on;

  assign psc_in  = {presc1, presc0};
  assign duty_in = {duty1, duty0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fresh <= 1'b1;
    else        fresh <= 1'b0;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    assign step[ch]     = tick && !fresh && (pre_q[ch] == psc_q[ch]);
    assign wrap[ch]     = step[ch] && (phase[ch] == {CW{1'b1}});
    assign blink_on[ch] = phase[ch] < duty_q[ch];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        psc_q[ch]  <= '0;
        duty_q[ch] <= '0;
        pre_q[ch]  <= '0;
        phase[ch]  <= '0;
      end else begin
        if (fresh || wrap[ch]) begin
          psc_q[ch]  <= psc_in[ch];
          duty_q[ch] <= duty_in[ch];
        end
        if (tick && !fresh)
          pre_q[ch] <= step[ch] ? '0 : pre_q[ch] + 1'b1;
        if (step[ch])
          phase[ch] <= phase[ch] + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NLED; i++) begin : g_led
    logic [1:0] mode;
    logic       on;
    assign mode      = led_sel[2*i +: 2];
    assign on        = (mode == 2'b01) ||
                       (mode == 2'b10 && blink_on[0]) ||
                       (mode == 2'b11 && blink_on[1]);
    assign led_oe[i] = on;
    assign led_n[i]  = ~on;
  end
endmodule

// File: rtl/led_blink_dimmer_chk.sv
module led_blink_dimmer_chk #(
  parameter int CW   = 8,
  parameter int NLED = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               fresh,
  input logic [2*NLED-1:0]  led_sel,
  input logic [NLED-1:0]    led_n,
  input logic [NLED-1:0]    led_oe,
  input logic [1:0][CW-1:0] phase,
  input logic [1:0][CW-1:0] duty_q,
  input logic [1:0]         wrap
);
  // R2
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    led_sel[1:0] == 2'b00 |-> !led_oe[0] && led_n[0]);

  // R3
  forced_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    led_sel[1:0] == 2'b01 |-> led_oe[0] && !led_n[0]);

  // R7
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    duty_q[0] == '0 && led_sel[1:0] == 2'b10 |-> !led_oe[0]);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));

  // R9
  shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fresh && !wrap[0] |=> $stable(duty_q[0]));

  // R10
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap[1] |=> phase[1] == '0);
endmodule

bind led_blink_dimmer led_blink_dimmer_chk #(.CW(CW), .NLED(NLED)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .fresh(fresh), .led_sel(led_sel),
  .led_n(led_n), .led_oe(led_oe), .phase(phase), .duty_q(duty_q), .wrap(wrap)
);

// File: tb/tb_led_blink_dimmer.sv
`timescale 1ns/1ps
module tb_led_blink_dimmer;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [7:0] presc0 = 0, duty0 = 0, presc1 = 0, duty1 = 0, led_sel = 0;
  logic [3:0] led_n, led_oe;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  led_blink_dimmer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .presc0(presc0), .duty0(duty0),
    .presc1(presc1), .duty1(duty1), .led_sel(led_sel), .led_n(led_n), .led_oe(led_oe)
  );

  // {led_sel, ticks to apply, expected led_oe}; psc=0, duty0=0x80, duty1=0x40
  localparam logic [23:0] VEC [13] = '{
    {8'h00, 12'd0,   4'b0000},  // R2
    {8'h55, 12'd10,  4'b1111},  // R3  phase 10
    {8'hAA, 12'd48,  4'b1111},  // R4  phase 58
    {8'hFF, 12'd10,  4'b0000},  // R5  phase 68
    {8'hAA, 12'd0,   4'b1111},  // R4
    {8'hE4, 12'd0,   4'b0110},  // R6
    {8'h1B, 12'd60,  4'b0100},  // R6  phase 128
    {8'hAA, 12'd127, 4'b0000},  // R4  phase 255
    {8'hAA, 12'd1,   4'b1111},  // R10 phase 0
    {8'hFF, 12'd63,  4'b1111},  // R5  phase 63
    {8'hFF, 12'd1,   4'b0000},  // R5  phase 64
    {8'hAA, 12'd63,  4'b1111},  // R4  phase 127
    {8'hAA, 12'd1,   4'b0000}   // R4  phase 128
  };
  localparam string VTAG [13] = '{"R2","R3","R4","R5","R4","R6","R6","R4","R10","R5","R5","R4","R4"};

  task automatic check(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
    tick = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
  endtask

  initial begin
    #1_600_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    duty0 = 8'h80; duty1 = 8'h40; led_sel = 8'hAA;
    do_reset();
    check(led_oe == 4'b1111, "R1", led_oe, 4'b1111);

    for (int v = 0; v < 13; v++) begin
      led_sel = VEC[v][23:16];
      run(int'(VEC[v][15:4]));
      #1;
      check(led_oe == VEC[v][3:0], VTAG[v], led_oe, VEC[v][3:0]);
      check(led_n == ~led_oe, "R2", led_n, ~led_oe);
    end

    // R9: mid-period duty change is deferred to the wrap
    duty0 = 8'hFF;
    run(1);
    check(led_oe == 4'b0000, "R9", led_oe, 4'b0000);
    run(127);
    check(led_oe == 4'b1111, "R9", led_oe, 4'b1111);
    run(200);
    check(led_oe == 4'b1111, "R9", led_oe, 4'b1111);

    // R7: duty zero never lights the LED over a full period
    duty0 = 8'h00;
    run(56);
    check(led_oe == 4'b0000, "R7", led_oe, 4'b0000);
    for (int k = 0; k < 255; k++) begin
      run(1);
      check(led_oe == 4'b0000, "R7", led_oe, 4'b0000);
    end

    // R8: prescale 2 advances phase every third tick
    presc0 = 8'd2; duty0 = 8'd1; led_sel = 8'hAA;
    do_reset();
    check(led_oe == 4'b1111, "R1", led_oe, 4'b1111);
    repeat (5) @(negedge clk);
    #1;
    check(led_oe == 4'b1111, "R8", led_oe, 4'b1111);
    run(2);
    check(led_oe == 4'b1111, "R8", led_oe, 4'b1111);
    run(1);
    check(led_oe == 4'b0000, "R8", led_oe, 4'b0000);
    run(764);
    check(led_oe == 4'b0000, "R8", led_oe, 4'b0000);
    run(1);
    check(led_oe == 4'b1111, "R10", led_oe, 4'b1111);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule